// File: doc/BRIEF.md
# Boundary Test Access Port Controller

This block is the target side of an IEEE 1149.1 test port. A host drives the test clock, the mode-select line and serial data in, and reads serial data out. The block walks the sixteen-state controller, holds an 8-bit instruction, and routes the serial path through one of four data registers:

- a one-bit bypass stage;
- a 32-bit identification register;
- a 65-bit read-return register;
- a path to external private chains, reached through an input pin.

Decoded selection and capture/shift/update strobes go out to the rest of the chip.

The read-return register reports when a pending read has finished. Its first bit out is a sentinel. The sentinel reads 0 while no data has been handed over and 1 once a payload was taken at capture. A host therefore re-enters capture and polls the first bit until it sees 1, then keeps shifting to collect the 64-bit payload.

The payload arrives on a valid/ready pair:

- The producer raises `rr_valid` with `rr_data` and holds both until a transfer happens.
- The block raises `rr_ready` only in the Capture-DR cycle while the read-return register is selected.
- A transfer is a rising test-clock edge with both valid and ready high.
- The block never stalls the producer beyond waiting for the host's next capture.

Top module: `scan_access_port`

## Requirements
- R1: `tap_state` uses this fixed code, and transitions follow the standard TMS graph on the rising edge of `tck`.
  - 15 = Test-Logic-Reset, 14 = Capture-IR, 13 = Update-IR, 12 = Run-Test-Idle.
  - 11 = Pause-IR, 10 = Shift-IR, 9 = Exit1-IR, 8 = Exit2-IR.
  - 7 = Select-DR, 6 = Capture-DR, 5 = Update-DR, 4 = Select-IR.
  - 3 = Pause-DR, 2 = Shift-DR, 1 = Exit1-DR, 0 = Exit2-DR.
  - Examples: Select-IR with TMS=1 goes to 15. Update-DR or Update-IR with TMS=1 goes to Select-DR, and with TMS=0 goes to Run-Test-Idle.
- R2: `trst_n` low puts `tap_state` at 15 and `instr` at the identification code 8'h01 at once, without a clock edge.
- R3: Five consecutive rising edges with TMS=1 reach state 15 from any state.
- R4: The instruction register shifts LSB first from `tdi`. In Capture-IR it loads 8'b0000_0001, so the first two bits out are 1 then 0. `instr` changes only on the falling edge in Update-IR or Test-Logic-Reset.
- R5: Test-Logic-Reset loads the identification code 8'h01 into `instr`.
- R6: Code 8'hFF selects the bypass stage (`dr_sel`=0). It captures 0, so a shifted pattern emerges one bit late with a 0 first.
- R7: Code 8'h01 selects the identification register (`dr_sel`=1). It captures {version 4'h3, part 16'hB5A7, maker 11'h2C9, 1'b1}, bit 0 first.
- R8: Code 8'h2C selects the read-return register (`dr_sel`=2). Capture loads {`rr_data`, 1'b1} when `rr_valid` is high and all zeros otherwise. It shifts 65 bits, sentinel first.
- R9: `rr_ready` is high only in Capture-DR with `dr_sel`=2.
- R10: Codes 8'h40 to 8'h5F select the external path (`dr_sel`=3), with `tdo` following `ext_so`. Every other undecoded code selects bypass.
- R11: `tdo` and `tdo_en` update on the falling edge of `tck`. `tdo_en` is high only while the state is Shift-IR or Shift-DR.
- R12: `dr_capture`, `dr_shift` and `dr_update` are high exactly in Capture-DR, Shift-DR and Update-DR. At most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Output enable for `tdo` (high in shift states) |
| ext_so | input | 1 | Serial return from external private chains |
| rr_valid | input | 1 | Read-return payload valid |
| rr_ready | output | 1 | Read-return register accepting payload |
| rr_data | input | 64 | Read-return payload |
| instr | output | 8 | Current (updated) instruction |
| dr_sel | output | 2 | Selected data register: 0 bypass, 1 id, 2 read-return, 3 external |
| dr_capture | output | 1 | Capture-DR strobe |
| dr_shift | output | 1 | Shift-DR strobe |
| dr_update | output | 1 | Update-DR strobe |
| tap_state | output | 4 | Controller state code |

## Verification
The bench exercises the following corner cases; each names what a faulty design would do.

- **Sentinel before and after valid data.** A design that latched the payload without the sentinel, or forgot to clear it, would report completion too early.
- **Bypass stage bit 0.** A bypass stage that captured 1, or that had no delay, shows up on the first bit out.
- **Captured instruction pattern.** A swapped capture pattern or a reversed shift order makes the returned instruction bits differ from 1,0,0,...
- **Asynchronous reset while in Pause-IR.** The bench loads a non-identification instruction and then resets. A reset that waited for a clock, or that left the old instruction in place, is caught.
- **Five-ones escape and graph walk.** The bench uses them to catch transition mistakes.
- **Unknown and external code ranges.** These catch decode slips at the range edges.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_EX2DR = 4'd0,  ST_EX1DR = 4'd1,  ST_SHDR  = 4'd2,  ST_PADR = 4'd3,
    ST_SELIR = 4'd4,  ST_UPDR  = 4'd5,  ST_CAPDR = 4'd6,  ST_SELDR = 4'd7,
    ST_EX2IR = 4'd8,  ST_EX1IR = 4'd9,  ST_SHIR  = 4'd10, ST_PAIR = 4'd11,
    ST_IDLE  = 4'd12, ST_UPIR  = 4'd13, ST_CAPIR = 4'd14, ST_TLR  = 4'd15
  } port_state_e;

  typedef enum logic [1:0] {
    DSEL_BYP = 2'd0, DSEL_ID = 2'd1, DSEL_RR = 2'd2, DSEL_EXT = 2'd3
  } dr_sel_e;

  function automatic port_state_e step_state(port_state_e cur, logic m);
    case (cur)
      ST_TLR:   return m ? ST_TLR   : ST_IDLE;
      ST_IDLE:  return m ? ST_SELDR : ST_IDLE;
      ST_SELDR: return m ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: return m ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  return m ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: return m ? ST_UPDR  : ST_PADR;
      ST_PADR:  return m ? ST_EX2DR : ST_PADR;
      ST_EX2DR: return m ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  return m ? ST_SELDR : ST_IDLE;
      ST_SELIR: return m ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: return m ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  return m ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: return m ? ST_UPIR  : ST_PAIR;
      ST_PAIR:  return m ? ST_EX2IR : ST_PAIR;
      ST_EX2IR: return m ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  return m ? ST_SELDR : ST_IDLE;
      default:  return ST_TLR;
    endcase
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  output port_state_e st
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= step_state(st, tms);
  end
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
#(
  parameter int          IR_W   = 8,
  parameter logic [7:0]  ID_OP  = 8'h01
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  port_state_e     st,
  output logic            ir_so,
  output logic [IR_W-1:0] op
);
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(2'b01);
  localparam logic [IR_W-1:0] RST_OP  = IR_W'(ID_OP);

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sr <= CAP_PAT;
    else if (st == ST_CAPIR) sr <= CAP_PAT;
    else if (st == ST_SHIR)  sr <= {tdi, sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)             op <= RST_OP;
    else if (st == ST_TLR)   op <= RST_OP;
    else if (st == ST_UPIR)  op <= sr;
  end

  assign ir_so = sr[0];
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int           ID_W   = 32,
  parameter logic [31:0]  ID_VAL = 32'h1,
  parameter int           RR_W   = 64
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  port_state_e     st,
  input  dr_sel_e         sel,
  input  logic            rr_valid,
  input  logic [RR_W-1:0] rr_data,
  input  logic            ext_so,
  output logic            rr_ready,
  output logic            dr_so
);
  localparam int RR_LEN = RR_W + 1;

  logic              byp;
  logic [ID_W-1:0]   id_sr;
  logic [RR_LEN-1:0] rr_sr;
  logic              cap, sft;

  assign cap      = (st == ST_CAPDR);
  assign sft      = (st == ST_SHDR);
  assign rr_ready = cap && (sel == DSEL_RR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp   <= 1'b0;
      id_sr <= '0;
      rr_sr <= '0;
    end else if (cap) begin
      byp   <= 1'b0;
      id_sr <= ID_VAL[ID_W-1:0];
      rr_sr <= rr_valid ? {rr_data, 1'b1} : '0;
    end else if (sft) begin
      case (sel)
        DSEL_BYP: byp   <= tdi;
        DSEL_ID:  id_sr <= {tdi, id_sr[ID_W-1:1]};
        DSEL_RR:  rr_sr <= {tdi, rr_sr[RR_LEN-1:1]};
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DSEL_ID:  dr_so = id_sr[0];
      DSEL_RR:  dr_so = rr_sr[0];
      DSEL_EXT: dr_so = ext_so;
      default:  dr_so = byp;
    endcase
  end
endmodule

// File: rtl/scan_access_port.sv
module scan_access_port
  import scan_pkg::*;
#(
  parameter int          IR_W     = 8,
  parameter int          RR_W     = 64,
  parameter logic [3:0]  VERSION  = 4'h3,
  parameter logic [15:0] PART     = 16'hB5A7,
  parameter logic [10:0] MAKER    = 11'h2C9,
  parameter logic [7:0]  OP_ID    = 8'h01,
  parameter logic [7:0]  OP_BYP   = 8'hFF,
  parameter logic [7:0]  OP_RR    = 8'h2C,
  parameter logic [7:0]  EXT_LO   = 8'h40,
  parameter logic [7:0]  EXT_HI   = 8'h5F
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_en,
  input  logic            ext_so,
  input  logic            rr_valid,
  output logic            rr_ready,
  input  logic [63:0]     rr_data,
  output logic [7:0]      instr,
  output logic [1:0]      dr_sel,
  output logic            dr_capture,
  output logic            dr_shift,
  output logic            dr_update,
  output logic [3:0]      tap_state
);
  localparam logic [31:0] ID_VAL = {VERSION, PART, MAKER, 1'b1};

  port_state_e     st;
  dr_sel_e         sel;
  logic            ir_so, dr_so;
  logic [IR_W-1:0] op;

  scan_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

  scan_ir #(.IR_W(IR_W), .ID_OP(OP_ID)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .ir_so(ir_so), .op(op)
  );

  always_comb begin
    if (op == IR_W'(OP_ID))                               sel = DSEL_ID;
    else if (op == IR_W'(OP_RR))                          sel = DSEL_RR;
    else if (op >= IR_W'(EXT_LO) && op <= IR_W'(EXT_HI)) sel = DSEL_EXT;
    else                                                  sel = DSEL_BYP;
  end

  scan_dr #(.ID_W(32), .ID_VAL(ID_VAL), .RR_W(RR_W)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .sel(sel),
    .rr_valid(rr_valid), .rr_data(rr_data[RR_W-1:0]), .ext_so(ext_so),
    .rr_ready(rr_ready), .dr_so(dr_so)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == ST_SHIR) || (st == ST_SHDR);
      tdo    <= (st == ST_SHIR) ? ir_so : (st == ST_SHDR) ? dr_so : 1'b0;
    end
  end

  assign instr      = 8'(op);
  assign dr_sel     = sel;
  assign dr_capture = (st == ST_CAPDR);
  assign dr_shift   = (st == ST_SHDR);
  assign dr_update  = (st == ST_UPDR);
  assign tap_state  = st;
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] tap_state,
  input logic       tdo_en,
  input logic       rr_ready,
  input logic [1:0] dr_sel,
  input logic       dr_capture,
  input logic       dr_shift,
  input logic       dr_update,
  input logic [7:0] instr
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                   ones_cnt <= 3'd0;
    else if (!tms)                 ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5)     ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  selir_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == 4'd4 && tms) |=> (tap_state == 4'd15));

  // R1
  update_return_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ((tap_state == 4'd5 || tap_state == 4'd13) && !tms) |=> (tap_state == 4'd12));

  // R3
  five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (tap_state == 4'd15));

  // R4
  instr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state != 4'd13 && tap_state != 4'd15) |-> $stable(instr));

  // R9
  ready_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    rr_ready |-> (dr_capture && dr_sel == 2'd2));

  // R11
  out_enable_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (tap_state == 4'd10 || tap_state == 4'd2));

  // R12
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({dr_capture, dr_shift, dr_update}));
endmodule

bind scan_access_port scan_port_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tap_state(tap_state),
  .tdo_en(tdo_en), .rr_ready(rr_ready), .dr_sel(dr_sel),
  .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
  .instr(instr)
);

// File: tb/scan_access_port_bench.sv
module scan_access_port_bench;
  localparam time TCK_PERIOD = 20;
  localparam logic [31:0] EXP_ID = {4'h3, 16'hB5A7, 11'h2C9, 1'b1};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, ext_so = 1'b0;
  logic rr_valid = 1'b0;
  logic [63:0] rr_data = '0;
  logic tdo, tdo_en, rr_ready, dr_capture, dr_shift, dr_update;
  logic [7:0] instr;
  logic [1:0] dr_sel;
  logic [3:0] tap_state;

  int n_checks = 0, n_errors = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #(TCK_PERIOD/2) tck = ~tck;

  scan_access_port u_scan_access_port (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .ext_so(ext_so), .rr_valid(rr_valid), .rr_ready(rr_ready), .rr_data(rr_data),
    .instr(instr), .dr_sel(dr_sel), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .tap_state(tap_state)
  );

  task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every enabled output bit is compared with the next expected one
  initial forever begin
    @(posedge tck);
    if (tdo_en === 1'b1) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R11: actual=%b expected=no shifted bit", tdo);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (tdo !== e) begin
          n_errors++;
          $display("FAIL %s: actual=%b expected=%b", t, tdo, e);
        end
      end
    end
  end

  task automatic step(logic m, logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic push_exp(logic [127:0] v, int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v[i]); tag_q.push_back(tag);
    end
  endtask

  // from Run-Test-Idle back to Run-Test-Idle
  task automatic scan_ir(logic [7:0] v, string tag);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check_eq("R11", {63'b0, tdo_en}, 64'd1);
    push_exp(128'h01, 8, "R4");
    for (int i = 0; i < 8; i++) step(i == 7, v[i]);
    step(1, 0);
    step(0, 0);
    check_eq(tag, {56'b0, instr}, {56'b0, v});
  endtask

  task automatic scan_dr(int n, logic [127:0] din, logic [127:0] exp,
                         logic exp_rdy, string tag);
    step(1, 0); step(0, 0);
    check_eq("R12", {61'b0, dr_capture, dr_shift, dr_update}, 64'd4);
    check_eq("R9", {63'b0, rr_ready}, {63'b0, exp_rdy});
    step(0, 0);
    check_eq("R12", {61'b0, dr_capture, dr_shift, dr_update}, 64'd2);
    check_eq("R9", {63'b0, rr_ready}, 64'd0);
    push_exp(exp, n, tag);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0);
    check_eq("R12", {61'b0, dr_capture, dr_shift, dr_update}, 64'd1);
    step(0, 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(TCK_PERIOD * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    logic [63:0] pay;
    pay = 64'hA5C3_0F96_1E2D_7B48;
    #(TCK_PERIOD * 2 + 3);
    check_eq("R2", {60'b0, tap_state}, 64'd15);
    check_eq("R5", {56'b0, instr}, 64'h01);
    check_eq("R11", {63'b0, tdo_en}, 64'd0);
    @(negedge tck); #1; trst_n = 1'b1;
    step(1, 0);
    check_eq("R1", {60'b0, tap_state}, 64'd15);
    step(0, 0);
    check_eq("R1", {60'b0, tap_state}, 64'd12);

    // R1 graph walk through the data column
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd7);
    step(0, 0); check_eq("R1", {60'b0, tap_state}, 64'd6);
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd1);
    step(0, 0); check_eq("R1", {60'b0, tap_state}, 64'd3);
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd0);
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd5);
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd7);
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd4);
    step(1, 0); check_eq("R1", {60'b0, tap_state}, 64'd15);
    step(0, 0);

    // R7 identification after reset
    check_eq("R7", {62'b0, dr_sel}, 64'd1);
    scan_dr(32, '0, {96'b0, EXP_ID}, 1'b0, "R7");

    // R6 bypass
    scan_ir(8'hFF, "R4");
    check_eq("R6", {62'b0, dr_sel}, 64'd0);
    scan_dr(16, 128'hC38C, {112'b0, 16'hC38C << 1}, 1'b0, "R6");

    // R10 unknown code falls back to bypass
    scan_ir(8'h33, "R4");
    check_eq("R10", {62'b0, dr_sel}, 64'd0);
    scan_dr(8, 128'h5B, {120'b0, 8'hB6}, 1'b0, "R10");

    // R10 external range edge
    scan_ir(8'h5F, "R4");
    check_eq("R10", {62'b0, dr_sel}, 64'd3);
    ext_so = 1'b1;
    scan_dr(4, '0, 128'hF, 1'b0, "R10");
    ext_so = 1'b0;
    scan_ir(8'h60, "R4");
    check_eq("R10", {62'b0, dr_sel}, 64'd0);

    // R8 sentinel zero while pending, then payload
    scan_ir(8'h2C, "R4");
    check_eq("R8", {62'b0, dr_sel}, 64'd2);
    scan_dr(65, '0, '0, 1'b1, "R8");
    rr_valid = 1'b1; rr_data = pay;
    scan_dr(65, '0, {63'b0, pay, 1'b1}, 1'b1, "R8");
    rr_valid = 1'b0;

    // R3 five ones from Pause-DR
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    check_eq("R3", {60'b0, tap_state}, 64'd3);
    for (int i = 0; i < 5; i++) step(1, 0);
    check_eq("R3", {60'b0, tap_state}, 64'd15);
    check_eq("R5", {56'b0, instr}, 64'h01);

    // R2 asynchronous reset in Pause-IR after loading bypass
    step(0, 0);
    scan_ir(8'hFF, "R4");
    step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    check_eq("R1", {60'b0, tap_state}, 64'd11);
    check_eq("R4", {56'b0, instr}, 64'hFF);
    #3; trst_n = 1'b0; #1;
    check_eq("R2", {60'b0, tap_state}, 64'd15);
    check_eq("R2", {56'b0, instr}, 64'h01);
    @(negedge tck); #1; trst_n = 1'b1;
    step(1, 0);

    check_eq("R11", {32'b0, 32'(exp_q.size())}, 64'd0);
    report();
  end
endmodule